// File: doc/BRIEF.md
# Four-Channel DMA Programming Register Front End

This block is the software-facing register file of a four-channel DMA engine. A host reaches it through an 8-bit data port and a 4-bit register offset, using one-cycle write and read strobes. Each channel keeps a 16-bit address and a 16-bit count. Because the port is only a byte wide, both halves of a 16-bit value share one offset. A single byte-pointer flip-flop, shared by all channels, picks the half. Software sets the pointer to its low state before a 16-bit access. The pointer then alternates on every access to a channel register.

Besides the channel registers, the block holds the per-channel mask bits, a per-channel mode field, a command byte, software request bits and a status byte with terminal-count flags. It also decodes master-clear, clear-all-masks and load-all-masks commands. A per-channel step input stands in for a completed transfer. Each step lowers the current count and advances the current address, so software can watch the residue shrink and see the terminal-count flag appear. Bus arbitration, handshakes with peripherals and memory cycles belong to other blocks.

Top module: `dma_chan_front`

## Requirements
- R1: After reset all mask bits read 1, all mode fields, the command byte, the request bits, the terminal-count flags and every channel address and count are zero, and the byte pointer selects the low byte.
- R2: Channel n address is at offset 2n and channel n count at 2n+1 (n = 0..3). Each read or write at offsets 0..7 reaches the low byte when the pointer is low and the high byte when it is high, and then flips the pointer.
- R3: A write to offset 0xC, whatever its data, returns the byte pointer to the low state.
- R4: Writing an address or count byte loads that byte into both the base and the current copy; reads return the current copy.
- R5: A write to offset 0xA sets the mask bit of channel data[1:0] to data[2] (1 = masked, 0 = enabled); other mask bits are unchanged. mask_o bit n is channel n.
- R6: A write to offset 0xE clears all four mask bits; a write to offset 0xF loads mask bit n from data bit n.
- R7: A write to offset 0xB stores data[7:2] as the mode field of channel data[1:0], presented on mode_o[6n+5:6n]; values such as 0x44, 0x48 and 0xC0 are stored unchanged in those bits.
- R8: A pulse on xfer_step[n] while the count is non-zero lowers channel n's current count by one and raises its current address by one.
- R9: A step while the current count is 0x0000 and auto-init is off wraps the count to 0xFFFF, still advances the address, and sets terminal-count flag n.
- R10: A read of offset 8 returns {request bits [7:4], terminal-count flags [3:0]} and clears the terminal-count flags.
- R11: A write to offset 0xD (master clear) sets all mask bits, zeroes the command byte, request bits and terminal-count flags, and returns the byte pointer to low; channel address, count and mode are kept.
- R12: When the channel's mode has auto-init set (write data bit 4), a step at count 0x0000 sets the terminal-count flag and reloads current address and count from their base copies.
- R13: A write to offset 8 stores the byte on cmd_o; a write to offset 9 sets request bit data[1:0] to data[2]; a read of offset 0xD returns 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe, one cycle per access |
| bus_rd | input | 1 | Register read strobe, one cycle per access |
| bus_off | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after bus_rd |
| xfer_step | input | 4 | Per-channel transfer-done pulse |
| mask_o | output | 4 | Channel mask bits, 1 = masked |
| mode_o | output | 24 | Mode fields, 6 bits per channel |
| cmd_o | output | 8 | Command byte |

## Verification
A byte pointer that has drifted out of step shows up on the next channel read as swapped byte halves. Every later access to offsets 0..7 stays out of phase until offset 0xC or 0xD is written. A wrong count or address is visible one cycle after the read strobe that samples it. A lost or duplicated step, or a missed auto-init reload, shifts the residue for good and moves the terminal-count flag to a different status read. Mask, mode and command errors appear on their output ports in the cycle after the write.

// File: rtl/dma_chan_front_pkg.sv
package dma_chan_front_pkg;
  localparam int NCH = 4;
  localparam int CSW = 2;
  localparam logic [3:0] OFF_STAT = 4'h8;
  localparam logic [3:0] OFF_REQ  = 4'h9;
  localparam logic [3:0] OFF_MSK1 = 4'hA;
  localparam logic [3:0] OFF_MODE = 4'hB;
  localparam logic [3:0] OFF_PCLR = 4'hC;
  localparam logic [3:0] OFF_MCLR = 4'hD;
  localparam logic [3:0] OFF_UNMK = 4'hE;
  localparam logic [3:0] OFF_MALL = 4'hF;
  // position of the auto-init flag inside a stored mode field (write bit 4)
  localparam int MODE_AUTO_BIT = 2;
endpackage

// File: rtl/dma_chan_front_bptr.sv
module dma_chan_front_bptr (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic step,
  output logic hi
);
  always_ff @(posedge clk) begin
    if (rst || clr) hi <= 1'b0;
    else if (step)  hi <= ~hi;
  end

  // R3
  ptr_clear_chk: assert property (@(posedge clk) disable iff (rst) clr |=> !hi);
  // R2
  ptr_flip_chk: assert property (@(posedge clk) disable iff (rst) (step && !clr) |=> (hi != $past(hi)));
endmodule

// File: rtl/dma_chan_front_chan.sv
module dma_chan_front_chan #(
  parameter int BW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_addr,
  input  logic            wr_cnt,
  input  logic            hi,
  input  logic [BW-1:0]   wdata,
  input  logic            step,
  input  logic            autoinit,
  output logic [2*BW-1:0] cur_addr,
  output logic [2*BW-1:0] cur_cnt,
  output logic            tc_evt
);
  localparam int AW = 2 * BW;

  logic [AW-1:0] base_addr, base_cnt;
  logic step_ok, wrap, reload;

  assign step_ok = step && !wr_addr && !wr_cnt;
  assign wrap    = step_ok && (cur_cnt == '0);
  assign reload  = wrap && autoinit;
  assign tc_evt  = wrap;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_addr <= '0;
      cur_addr  <= '0;
    end else if (wr_addr) begin
      if (hi) begin
        base_addr[AW-1:BW] <= wdata;
        cur_addr[AW-1:BW]  <= wdata;
      end else begin
        base_addr[BW-1:0] <= wdata;
        cur_addr[BW-1:0]  <= wdata;
      end
    end else if (step_ok) begin
      cur_addr <= reload ? base_addr : cur_addr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_cnt <= '0;
      cur_cnt  <= '0;
    end else if (wr_cnt) begin
      if (hi) begin
        base_cnt[AW-1:BW] <= wdata;
        cur_cnt[AW-1:BW]  <= wdata;
      end else begin
        base_cnt[BW-1:0] <= wdata;
        cur_cnt[BW-1:0]  <= wdata;
      end
    end else if (step_ok) begin
      cur_cnt <= reload ? base_cnt : cur_cnt - 1'b1;
    end
  end

  // R8
  step_dec_chk: assert property (@(posedge clk) disable iff (rst)
    (step_ok && cur_cnt != '0) |=> (cur_cnt == $past(cur_cnt) - 1'b1) && (cur_addr == $past(cur_addr) + 1'b1));
  // R9
  wrap_ffff_chk: assert property (@(posedge clk) disable iff (rst)
    (wrap && !autoinit) |=> (cur_cnt == '1));
  // R12
  autoinit_reload_chk: assert property (@(posedge clk) disable iff (rst)
    reload |=> (cur_cnt == $past(base_cnt)) && (cur_addr == $past(base_addr)));
endmodule

// File: rtl/dma_chan_front_ctrl.sv
module dma_chan_front_ctrl
  import dma_chan_front_pkg::*;
#(
  parameter int BW = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [3:0]            off,
  input  logic [BW-1:0]         wdata,
  input  logic                  stat_rd,
  input  logic [NCH-1:0]        tc_evt,
  output logic [NCH-1:0]        mask,
  output logic [NCH*(BW-2)-1:0] mode_flat,
  output logic [BW-1:0]         cmd,
  output logic [NCH-1:0]        req,
  output logic [NCH-1:0]        tc
);
  localparam int MW = BW - 2;

  logic [MW-1:0]  mode_q [NCH];
  logic [CSW-1:0] sel;
  logic           mclr;

  assign sel  = wdata[CSW-1:0];
  assign mclr = wr_en && (off == OFF_MCLR);

  always_ff @(posedge clk) begin
    if (rst || mclr)                        mask <= '1;
    else if (wr_en && off == OFF_MSK1)      mask[sel] <= wdata[2];
    else if (wr_en && off == OFF_UNMK)      mask <= '0;
    else if (wr_en && off == OFF_MALL)      mask <= wdata[NCH-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst || mclr)                        req <= '0;
    else if (wr_en && off == OFF_REQ)       req[sel] <= wdata[2];
  end

  always_ff @(posedge clk) begin
    if (rst || mclr)                        cmd <= '0;
    else if (wr_en && off == OFF_STAT)      cmd <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || mclr) tc <= '0;
    else             tc <= (stat_rd ? '0 : tc) | tc_evt;
  end

  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_mode
      always_ff @(posedge clk) begin
        if (rst) mode_q[g] <= '0;
        else if (wr_en && off == OFF_MODE && sel == CSW'(g)) mode_q[g] <= wdata[BW-1:2];
      end
      assign mode_flat[g*MW +: MW] = mode_q[g];
    end
  endgenerate

  // R5
  mask_single_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && off == OFF_MSK1) |=> (mask[$past(sel)] == $past(wdata[2])));
  // R11
  mclr_state_chk: assert property (@(posedge clk) disable iff (rst)
    mclr |=> (mask == '1) && (tc == '0) && (req == '0) && (cmd == '0));
  // R10
  stat_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && !mclr) |=> (tc == $past(tc_evt)));
  // R6
  unmask_all_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && off == OFF_UNMK) |=> (mask == '0));
endmodule

// File: rtl/dma_chan_front.sv
module dma_chan_front
  import dma_chan_front_pkg::*;
#(
  parameter int BW = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [3:0]            bus_off,
  input  logic [BW-1:0]         bus_wdata,
  output logic [BW-1:0]         bus_rdata,
  input  logic [NCH-1:0]        xfer_step,
  output logic [NCH-1:0]        mask_o,
  output logic [NCH*(BW-2)-1:0] mode_o,
  output logic [BW-1:0]         cmd_o
);
  localparam int AW = 2 * BW;
  localparam int MW = BW - 2;

  logic           in_ch, is_cnt, ptr_hi, ptr_clr, ptr_step, stat_rd;
  logic [CSW-1:0] ch_sel;
  logic [AW-1:0]  cur_addr [NCH];
  logic [AW-1:0]  cur_cnt  [NCH];
  logic [NCH-1:0] tc_evt, req, tc;
  logic [AW-1:0]  ch_val;
  logic [BW-1:0]  rd_mux;

  assign in_ch    = !bus_off[3];
  assign is_cnt   = bus_off[0];
  assign ch_sel   = bus_off[2:1];
  assign ptr_step = (bus_wr || bus_rd) && in_ch;
  assign ptr_clr  = bus_wr && (bus_off == OFF_PCLR || bus_off == OFF_MCLR);
  assign stat_rd  = bus_rd && (bus_off == OFF_STAT);

  dma_chan_front_bptr u_bptr (
    .clk  (clk),
    .rst  (rst),
    .clr  (ptr_clr),
    .step (ptr_step),
    .hi   (ptr_hi)
  );

  dma_chan_front_ctrl #(.BW(BW)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (bus_wr),
    .off       (bus_off),
    .wdata     (bus_wdata),
    .stat_rd   (stat_rd),
    .tc_evt    (tc_evt),
    .mask      (mask_o),
    .mode_flat (mode_o),
    .cmd       (cmd_o),
    .req       (req),
    .tc        (tc)
  );

  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_chan
      logic sel_me;
      assign sel_me = bus_wr && in_ch && (ch_sel == CSW'(g));
      dma_chan_front_chan #(.BW(BW)) u_chan (
        .clk      (clk),
        .rst      (rst),
        .wr_addr  (sel_me && !is_cnt),
        .wr_cnt   (sel_me && is_cnt),
        .hi       (ptr_hi),
        .wdata    (bus_wdata),
        .step     (xfer_step[g]),
        .autoinit (mode_o[g*MW + MODE_AUTO_BIT]),
        .cur_addr (cur_addr[g]),
        .cur_cnt  (cur_cnt[g]),
        .tc_evt   (tc_evt[g])
      );
    end
  endgenerate

  always_comb begin
    ch_val = is_cnt ? cur_cnt[ch_sel] : cur_addr[ch_sel];
    rd_mux = '0;
    if (in_ch)                      rd_mux = ptr_hi ? ch_val[AW-1:BW] : ch_val[BW-1:0];
    else if (bus_off == OFF_STAT)   rd_mux = {req, tc};
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  // R13
  temp_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_off == OFF_MCLR) |=> (bus_rdata == '0));
endmodule

// File: tb/dma_chan_front_bench.sv
`timescale 1ns/1ps
module dma_chan_front_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0]  bus_off = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [3:0]  xfer_step = '0;
  logic [3:0]  mask_o;
  logic [23:0] mode_o;
  logic [7:0]  cmd_o;

  always #2 clk = ~clk;

  dma_chan_front u_dma_chan_front (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_off(bus_off),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .xfer_step(xfer_step),
    .mask_o(mask_o), .mode_o(mode_o), .cmd_o(cmd_o)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  // reference model
  logic [15:0] m_addr [4], m_cnt [4], m_baddr [4], m_bcnt [4];
  logic [5:0]  m_mode [4];
  logic [3:0]  m_mask, m_req, m_tc;
  logic [7:0]  m_cmd;
  logic        m_hi;

  function automatic logic [7:0] pick(input logic [15:0] v, input logic h);
    return h ? v[15:8] : v[7:0];
  endfunction

  function automatic logic [23:0] exp_mode();
    logic [23:0] r;
    for (int i = 0; i < 4; i++) r[i*6 +: 6] = m_mode[i];
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 4; i++) begin
      m_addr[i] = 0; m_cnt[i] = 0; m_baddr[i] = 0; m_bcnt[i] = 0; m_mode[i] = 0;
    end
    m_mask = 4'hF; m_req = 0; m_tc = 0; m_cmd = 0; m_hi = 0;
  endtask

  task automatic wr(input logic [3:0] off, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_off = off; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    if (off < 8) begin
      int c = off >> 1;
      if (off[0]) begin
        if (m_hi) begin m_cnt[c][15:8] = d; m_bcnt[c][15:8] = d; end
        else      begin m_cnt[c][7:0]  = d; m_bcnt[c][7:0]  = d; end
      end else begin
        if (m_hi) begin m_addr[c][15:8] = d; m_baddr[c][15:8] = d; end
        else      begin m_addr[c][7:0]  = d; m_baddr[c][7:0]  = d; end
      end
      m_hi = ~m_hi;
    end else case (off)
      4'h8: m_cmd = d;
      4'h9: m_req[d[1:0]] = d[2];
      4'hA: m_mask[d[1:0]] = d[2];
      4'hB: m_mode[d[1:0]] = d[7:2];
      4'hC: m_hi = 0;
      4'hD: begin m_hi = 0; m_mask = 4'hF; m_req = 0; m_tc = 0; m_cmd = 0; end
      4'hE: m_mask = 0;
      default: m_mask = d[3:0];
    endcase
  endtask

  task automatic rd(input logic [3:0] off, output logic [7:0] q, output logic [7:0] e);
    @(negedge clk);
    bus_rd = 1'b1; bus_off = off;
    @(negedge clk);
    bus_rd = 1'b0;
    q = bus_rdata;
    e = 8'h00;
    if (off < 8) begin
      e = pick(off[0] ? m_cnt[off >> 1] : m_addr[off >> 1], m_hi);
      m_hi = ~m_hi;
    end else if (off == 4'h8) begin
      e = {m_req, m_tc};
      m_tc = 0;
    end
  endtask

  task automatic step(input logic [3:0] s);
    @(negedge clk);
    xfer_step = s;
    @(negedge clk);
    xfer_step = '0;
    for (int i = 0; i < 4; i++) if (s[i]) begin
      if (m_cnt[i] == 0) begin
        m_tc[i] = 1'b1;
        if (m_mode[i][2]) begin m_cnt[i] = m_bcnt[i]; m_addr[i] = m_baddr[i]; end
        else begin m_cnt[i] = 16'hFFFF; m_addr[i] = m_addr[i] + 1; end
      end else begin
        m_cnt[i] = m_cnt[i] - 1; m_addr[i] = m_addr[i] + 1;
      end
    end
  endtask

  task automatic ports(input string req);
    check({req, " mask"}, 32'(mask_o), 32'(m_mask));
    check({req, " mode"}, 32'(mode_o), 32'(exp_mode()));
    check({req, " cmd"},  32'(cmd_o),  32'(m_cmd));
  endtask

  task automatic put16(input logic [3:0] off, input logic [15:0] v);
    wr(4'hC, 8'h00);
    wr(off, v[7:0]);
    wr(off, v[15:8]);
  endtask

  task automatic get16(input logic [3:0] off, input string req);
    logic [7:0] q, e;
    wr(4'hC, 8'h5A);
    rd(off, q, e); check({req, " lo"}, 32'(q), 32'(e));
    rd(off, q, e); check({req, " hi"}, 32'(q), 32'(e));
  endtask

  initial begin
    logic [7:0] q, e;
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    ports("R1");
    rd(4'h8, q, e); check("R1 status", 32'(q), 32'h0);
    rd(4'h2, q, e); check("R1 addr lo", 32'(q), 32'h0);
    rd(4'h2, q, e); check("R1 addr hi", 32'(q), 32'h0);
    // R2 R4 byte order, base/current
    put16(4'h4, 16'hBEEF);
    get16(4'h4, "R2 R4 chan2 addr");
    rd(4'h4, q, e); check("R2 wrapped-ptr lo", 32'(q), 32'hEF);
    // R3 clear pointer mid-sequence
    wr(4'hC, 8'hFF);
    rd(4'h4, q, e); check("R3 after clear", 32'(q), 32'hEF);
    // R9 count 0 then step -> FFFF, TC set
    put16(4'h1, 16'h0000);
    step(4'b0001);
    get16(4'h1, "R9 wrap");
    rd(4'h8, q, e); check("R10 tc set", 32'(q), 32'h01);
    rd(4'h8, q, e); check("R10 tc cleared", 32'(q), 32'h00);
    // R12 auto-init reload
    wr(4'hB, 8'h54 | 8'h3);
    put16(4'h7, 16'h0001);
    put16(4'h6, 16'h1000);
    step(4'b1000); step(4'b1000); step(4'b1000);
    get16(4'h7, "R12 count reload");
    get16(4'h6, "R12 addr");
    rd(4'h8, q, e); check("R12 tc", 32'(q), 32'(e));
    // R7 mode values, R13 request/command/temp
    wr(4'hB, 8'h44); wr(4'hB, 8'h49); wr(4'hB, 8'hC2); ports("R7");
    wr(4'h9, 8'h05); wr(4'h8, 8'hA5); ports("R13");
    rd(4'h8, q, e); check("R13 req bits", 32'(q), 32'(e));
    rd(4'hD, q, e); check("R13 temp", 32'(q), 32'h00);
    // R6 and R11
    wr(4'hE, 8'h00); ports("R6 clear");
    wr(4'hF, 8'h0A); ports("R6 load");
    wr(4'h0, 8'h11);
    wr(4'hD, 8'h00); ports("R11");
    rd(4'h8, q, e); check("R11 status", 32'(q), 32'h00);
    get16(4'h4, "R11 addr kept");

    // constrained random mix
    for (int it = 0; it < 3000; it++) begin
      int op = $urandom_range(0, 99);
      logic [7:0] d = 8'($urandom);
      if (op < 25)      wr(4'($urandom_range(0, 7)), d);
      else if (op < 50) begin rd(4'($urandom_range(0, 7)), q, e); check("R2 R4 random read", 32'(q), 32'(e)); end
      else if (op < 58) begin wr(4'hA, d); ports("R5"); end
      else if (op < 64) begin wr(4'hB, d); ports("R7"); end
      else if (op < 80) step(4'($urandom));
      else if (op < 86) begin rd(4'h8, q, e); check("R10 random status", 32'(q), 32'(e)); end
      else if (op < 90) wr(4'hC, d);
      else if (op < 91) begin wr(4'hD, d); ports("R11"); end
      else if (op < 93) begin wr(4'hE, d); ports("R6"); end
      else if (op < 95) begin wr(4'hF, d); ports("R6"); end
      else if (op < 98) wr(4'h9, d);
      else begin wr(4'h8, d); ports("R13"); end
    end
    for (int c = 0; c < 8; c++) get16(4'(c), "R8 final");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule